// File: doc/BRIEF.md
# Sixteen-Lane Memory Access Coalescer

The block accepts one memory request from a group of sixteen lanes: each lane carries an active bit and a byte address, and all lanes share one element size of 4, 8 or 16 bytes. It folds the active lanes into as few naturally aligned memory segments as it can. It then issues one transaction per segment, each naming a base address, a byte count and the lanes it serves. The request is taken in a single cycle while the block is idle. Transactions leave one per cycle under a valid/ready handshake, and a one-cycle `done` pulse closes the request.

Two grouping policies exist. The default policy sweeps from the lowest-numbered unserved lane. That lane opens a 128-byte window, and every pending lane inside the window joins the transaction, whatever its lane order. The transaction is then halved toward 64 or 32 bytes while all of its lanes stay inside one half. The strict policy is selected per request. It allows a single access only when the active lanes follow an in-order, size-aligned pattern, and it otherwise falls back to one access per active lane.

Top module: `mem_coalescer`

## Requirements
- R1: After reset `txn_valid` and `done` are low and `req_ready` is high.
- R2: Every transaction base is a multiple of its byte count, every lane in its lane mask lies inside `[base, base+bytes)`, and across one request the lane masks are disjoint and together equal the active mask.
- R3: In the default policy the next transaction is opened by the lowest-numbered unserved lane. It serves exactly the unserved active lanes whose addresses share that lane's 128-byte aligned block.
- R4: In the default policy the byte count is the smallest of 32, 64 or 128 whose aligned block around the opening lane still holds every lane of the transaction.
- R5: `req_esz` encodes the element size as 0 = 4 bytes, 1 = 8 bytes, 2 or 3 = 16 bytes. Address bits below the element size are ignored.
- R6: In the strict policy (`req_legacy` = 1), a request where every active lane k addresses element k of a region of 16 elements, with the region start a multiple of the region size, yields exactly one transaction. That transaction has base = region start, bytes = 16 × element size, and lanes = the active mask.
- R7: In the strict policy, inactive lanes never prevent the single access of R6.
- R8: A strict-policy request that breaks R6 yields one transaction per active lane in ascending lane order. Each has base = that lane's address aligned down to the element size, bytes = element size, and a one-hot lane mask.
- R9: While `txn_valid` is high and `txn_ready` is low, base, bytes and lanes hold steady. At most one transaction completes per cycle.
- R10: `done` pulses for exactly one cycle, in the cycle after the last transaction handshake. `req_ready` stays low from acceptance until then.
- R11: A request with no active lane issues no transaction, and `done` pulses in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_legacy | input | 1 | Select strict in-order policy |
| req_esz | input | 2 | Element size code |
| req_mask | input | LANES | Active bit per lane |
| req_addr | input | LANES*AW | Lane byte addresses, lane k at bits k*AW upward |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Transaction accepted by the memory side |
| txn_base | output | AW | Transaction base byte address |
| txn_bytes | output | BYTES_W | Transaction size in bytes |
| txn_lanes | output | LANES | Lanes served by the transaction |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
Default-policy requests are driven in several forms: contiguous, permuted, scattered over several blocks, and started off a 64-byte boundary. Together these separate correct window membership from order sensitivity and show whether halving stops at the right level. Strict-policy requests are driven as perfect in-order regions for each element size, with some lanes switched off, and with swapped lanes or a misaligned start. These expose a checker that is too lax, because it merges a broken pattern, or too strict, because it splits over idle lanes. Empty masks and addresses with stray low bits probe the edge handling, and a randomly stalled `txn_ready` tests that transactions hold while stalled.

// File: rtl/coal_pkg.sv
package coal_pkg;
   // element size code to log2 of the element byte count
   function automatic int unsigned esz_lg(input logic [1:0] code);
      case (code)
         2'd0:    return 2;
         2'd1:    return 3;
         default: return 4;
      endcase
   endfunction
endpackage

// File: rtl/coal_leader.sv
module coal_leader #(
   parameter int unsigned LANES = 16,
   localparam int unsigned IW = $clog2(LANES)
) (
   input  logic [LANES-1:0] pend,
   output logic [IW-1:0]    idx,
   output logic [LANES-1:0] onehot
);
   always_comb begin
      idx    = '0;
      onehot = '0;
      for (int i = LANES - 1; i >= 0; i--) begin
         if (pend[i]) begin
            idx    = IW'(i);
            onehot = LANES'(1) << i;
         end
      end
   end
endmodule

// File: rtl/coal_seg_pick.sv
module coal_seg_pick #(
   parameter int unsigned LANES      = 16,
   parameter int unsigned AW         = 32,
   parameter int unsigned SEG_LG     = 7,
   parameter int unsigned MIN_SEG_LG = 5,
   localparam int unsigned IW = $clog2(LANES)
) (
   input  logic [LANES*AW-1:0] addr_flat,
   input  logic [LANES-1:0]    pend,
   input  logic [IW-1:0]       lead_idx,
   output logic [AW-1:0]       lead_addr,
   output logic [LANES-1:0]    members,
   output logic [AW-1:0]       seg_base,
   output logic [4:0]          seg_lg
);
   logic [AW-1:0] a [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_unpack
      assign a[g]       = addr_flat[g*AW +: AW];
      assign members[g] = pend[g] && (a[g][AW-1:SEG_LG] == lead_addr[AW-1:SEG_LG]);
   end

   assign lead_addr = a[lead_idx];

   logic shrinking;
   logic same;
   int unsigned lg;

   always_comb begin
      lg        = SEG_LG;
      shrinking = 1'b1;
      for (int l = SEG_LG; l > MIN_SEG_LG; l--) begin
         same = 1'b1;
         for (int g = 0; g < LANES; g++) begin
            if (members[g] && (a[g][l-1] != lead_addr[l-1])) same = 1'b0;
         end
         if (shrinking && same) lg = l - 1;
         else shrinking = 1'b0;
      end
      seg_lg   = 5'(lg);
      seg_base = lead_addr & ~((AW'(1) << lg) - AW'(1));
   end
endmodule

// File: rtl/coal_legacy_chk.sv
module coal_legacy_chk #(
   parameter int unsigned LANES = 16,
   parameter int unsigned AW    = 32,
   localparam int unsigned IW = $clog2(LANES)
) (
   input  logic [LANES*AW-1:0] addr_flat,
   input  logic [LANES-1:0]    mask,
   input  logic [1:0]          esz,
   output logic                ok
);
   import coal_pkg::*;

   logic [AW-1:0] a [LANES];
   for (genvar g = 0; g < LANES; g++) begin : g_unpack
      assign a[g] = addr_flat[g*AW +: AW];
   end

   int unsigned elg;
   int unsigned rlg;
   logic found;
   logic [AW-1:0] region;

   always_comb begin
      elg    = esz_lg(esz);
      rlg    = elg + IW;
      found  = 1'b0;
      region = '0;
      for (int g = 0; g < LANES; g++) begin
         if (mask[g] && !found) begin
            region = a[g] >> rlg;
            found  = 1'b1;
         end
      end
      ok = 1'b1;
      for (int g = 0; g < LANES; g++) begin
         if (mask[g]) begin
            if ((a[g] >> rlg) != region) ok = 1'b0;
            if (IW'(a[g] >> elg) != IW'(g)) ok = 1'b0;
         end
      end
   end
endmodule

// File: rtl/mem_coalescer.sv
module mem_coalescer #(
   parameter int unsigned LANES      = 16,
   parameter int unsigned AW         = 32,
   parameter int unsigned SEG_LG     = 7,
   parameter int unsigned MIN_SEG_LG = 5,
   parameter int unsigned BYTES_W    = 9,
   parameter bit          LEGACY_EN  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_legacy,
   input  logic [1:0]          req_esz,
   input  logic [LANES-1:0]    req_mask,
   input  logic [LANES*AW-1:0] req_addr,
   output logic                txn_valid,
   input  logic                txn_ready,
   output logic [AW-1:0]       txn_base,
   output logic [BYTES_W-1:0]  txn_bytes,
   output logic [LANES-1:0]    txn_lanes,
   output logic                done
);
   import coal_pkg::*;

   localparam int unsigned IW      = $clog2(LANES);
   localparam int unsigned REG_MAX = IW + 4;
   localparam int unsigned TOP_LG  = (SEG_LG > REG_MAX) ? SEG_LG : REG_MAX;

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (MIN_SEG_LG < 4 || MIN_SEG_LG > SEG_LG) begin : g_bad_seg
      $error("segment sizes must satisfy 16 <= minimum <= maximum");
   end
   if (SEG_LG >= AW) begin : g_bad_aw
      $error("address too narrow for the segment size");
   end
   if (BYTES_W < TOP_LG + 1) begin : g_bad_bw
      $error("BYTES_W cannot hold the largest transaction size");
   end

   // request state
   logic                busy;
   logic                leg_q;
   logic                ok_q;
   logic [1:0]          esz_q;
   logic [LANES*AW-1:0] addr_q;
   logic [LANES-1:0]    pend_q;
   logic                done_q;

   // strict-policy verdict on the incoming request
   logic leg_ok;
   logic leg_sel;
   if (LEGACY_EN) begin : g_legacy
      coal_legacy_chk #(.LANES(LANES), .AW(AW)) u_leg (
         .addr_flat (req_addr),
         .mask      (req_mask),
         .esz       (req_esz),
         .ok        (leg_ok)
      );
      assign leg_sel = req_legacy;
   end else begin : g_no_legacy
      assign leg_ok  = 1'b0;
      assign leg_sel = 1'b0;
   end

   // lane selection
   logic [IW-1:0]    lead_idx;
   logic [LANES-1:0] lead_oh;
   logic [AW-1:0]    lead_addr;
   logic [LANES-1:0] seg_members;
   logic [AW-1:0]    seg_base;
   logic [4:0]       seg_lg;

   coal_leader #(.LANES(LANES)) u_lead (
      .pend   (pend_q),
      .idx    (lead_idx),
      .onehot (lead_oh)
   );

   coal_seg_pick #(
      .LANES(LANES), .AW(AW), .SEG_LG(SEG_LG), .MIN_SEG_LG(MIN_SEG_LG)
   ) u_seg (
      .addr_flat (addr_q),
      .pend      (pend_q),
      .lead_idx  (lead_idx),
      .lead_addr (lead_addr),
      .members   (seg_members),
      .seg_base  (seg_base),
      .seg_lg    (seg_lg)
   );

   // transaction formation
   int unsigned elg;
   int unsigned tlg;
   logic [LANES-1:0] sel_lanes;
   logic [AW-1:0]    sel_base;

   always_comb begin
      elg = esz_lg(esz_q);
      if (leg_q && ok_q) begin
         tlg       = elg + IW;
         sel_base  = (lead_addr >> tlg) << tlg;
         sel_lanes = pend_q;
      end else if (leg_q) begin
         tlg       = elg;
         sel_base  = (lead_addr >> tlg) << tlg;
         sel_lanes = lead_oh;
      end else begin
         tlg       = 32'(seg_lg);
         sel_base  = seg_base;
         sel_lanes = seg_members;
      end
   end

   assign txn_valid = busy;
   assign txn_base  = sel_base;
   assign txn_bytes = BYTES_W'(1) << tlg;
   assign txn_lanes = sel_lanes;
   assign req_ready = !busy;
   assign done      = done_q;

   logic [LANES-1:0] pend_next;
   assign pend_next = pend_q & ~sel_lanes;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         leg_q  <= 1'b0;
         ok_q   <= 1'b0;
         esz_q  <= '0;
         addr_q <= '0;
         pend_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy && req_valid) begin
            addr_q <= req_addr;
            pend_q <= req_mask;
            leg_q  <= leg_sel;
            ok_q   <= leg_ok;
            esz_q  <= req_esz;
            if (req_mask == '0) done_q <= 1'b1;
            else                busy   <= 1'b1;
         end else if (busy && txn_ready) begin
            pend_q <= pend_next;
            if (pend_next == '0) begin
               busy   <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/coal_chk.sv
module coal_chk #(
   parameter int unsigned LANES   = 16,
   parameter int unsigned AW      = 32,
   parameter int unsigned BYTES_W = 9
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_ready,
   input logic               txn_valid,
   input logic               txn_ready,
   input logic [AW-1:0]      txn_base,
   input logic [BYTES_W-1:0] txn_bytes,
   input logic [LANES-1:0]   txn_lanes,
   input logic [LANES-1:0]   pend,
   input logic               done
);
   AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> ((txn_base & (AW'(txn_bytes) - AW'(1))) == '0)); // R2

   AST_LANES_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> (txn_lanes != '0 && (txn_lanes & ~pend) == '0)); // R2

   AST_SIZE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |-> $onehot(txn_bytes)); // R4

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base)
                                     && $stable(txn_bytes) && $stable(txn_lanes))); // R9

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (req_ready && !txn_valid)); // R10

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
endmodule

bind mem_coalescer coal_chk #(.LANES(LANES), .AW(AW), .BYTES_W(BYTES_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .txn_valid (txn_valid),
   .txn_ready (txn_ready),
   .txn_base  (txn_base),
   .txn_bytes (txn_bytes),
   .txn_lanes (txn_lanes),
   .pend      (pend_q),
   .done      (done)
);

// File: tb/sim_mem_coalescer.sv
module sim_mem_coalescer;
   localparam int N  = 16;
   localparam int AW = 32;
   localparam int BW = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic            req_valid = 1'b0;
   logic            req_ready;
   logic            req_legacy = 1'b0;
   logic [1:0]      req_esz = '0;
   logic [N-1:0]    req_mask = '0;
   logic [N*AW-1:0] req_addr = '0;
   logic            txn_valid;
   logic            txn_ready = 1'b0;
   logic [AW-1:0]   txn_base;
   logic [BW-1:0]   txn_bytes;
   logic [N-1:0]    txn_lanes;
   logic            done;

   mem_coalescer u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_legacy(req_legacy), .req_esz(req_esz), .req_mask(req_mask),
      .req_addr(req_addr), .txn_valid(txn_valid), .txn_ready(txn_ready),
      .txn_base(txn_base), .txn_bytes(txn_bytes), .txn_lanes(txn_lanes),
      .done(done)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // stimulus and expectation
   logic [AW-1:0] la [N];
   logic [N-1:0]  lmask;
   logic [1:0]    lesz;
   logic          lleg;
   logic [AW-1:0] eb [N];
   int            ebytes [N];
   logic [N-1:0]  el [N];
   int            en;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int esize(input logic [1:0] c);
      return (c == 2'd0) ? 4 : (c == 2'd1) ? 8 : 16;
   endfunction

   task automatic build_exp();
      int es = esize(lesz);
      en = 0;
      if (lleg) begin
         bit legal = 1;
         bit found = 0;
         longint rb = 0;
         for (int k = 0; k < N; k++) begin
            if (lmask[k]) begin
               longint ak = longint'(la[k]) & ~longint'(es - 1);
               if (!found) begin
                  rb = ak - longint'(k * es);
                  found = 1;
               end
               if (ak != rb + longint'(k * es)) legal = 0;
            end
         end
         if (found && (rb < 0 || (rb % (16 * es)) != 0)) legal = 0;
         if (found && legal) begin
            eb[0] = AW'(rb); ebytes[0] = 16 * es; el[0] = lmask; en = 1;
         end else begin
            for (int k = 0; k < N; k++) begin
               if (lmask[k]) begin
                  eb[en] = la[k] & ~AW'(es - 1);
                  ebytes[en] = es;
                  el[en] = N'(1) << k;
                  en++;
               end
            end
         end
      end else begin
         logic [N-1:0] pend = lmask;
         while (pend != '0) begin
            int f = 0;
            logic [N-1:0] mem = '0;
            int pick = 128;
            for (int k = N - 1; k >= 0; k--) if (pend[k]) f = k;
            for (int k = 0; k < N; k++)
               if (pend[k] && (la[k] / 128) == (la[f] / 128)) mem[k] = 1'b1;
            for (int s = 128; s >= 32; s = s / 2) begin
               bit fits = 1;
               for (int k = 0; k < N; k++)
                  if (mem[k] && (la[k] / s) != (la[f] / s)) fits = 0;
               if (fits) pick = s;
            end
            eb[en] = (la[f] / pick) * pick;
            ebytes[en] = pick;
            el[en] = mem;
            en++;
            pend = pend & ~mem;
         end
      end
   endtask

   task automatic run_req(input string tag, input string sz_tag);
      int idx = 0;
      int cyc = 0;
      bit got_done = 0;
      bit prev_hs = 0;
      bit held = 0;
      logic [AW-1:0] hb = '0;
      logic [BW-1:0] hy = '0;
      logic [N-1:0]  hl = '0;
      logic [N-1:0]  served = '0;
      int es = esize(lesz);
      build_exp();
      @(negedge clk);
      chk(req_ready == 1'b1, "R10", "req_ready before request", req_ready, 1);
      req_valid  = 1'b1;
      req_legacy = lleg;
      req_esz    = lesz;
      req_mask   = lmask;
      for (int k = 0; k < N; k++) req_addr[k*AW +: AW] = la[k];
      @(negedge clk);
      req_valid = 1'b0;
      while (!got_done && cyc < 100) begin
         if (done) begin
            got_done = 1;
            if (en == 0) chk(cyc == 0, "R11", "done delay on empty mask", cyc, 0);
            else chk(prev_hs, "R10", "done right after last handshake", prev_hs, 1);
            chk(idx == en, tag, "transaction count", idx, en);
            chk(served == lmask, "R2", "union of lane masks", served, lmask);
            chk(txn_valid == 1'b0, "R11", "no transaction at done", txn_valid, 0);
         end else begin
            prev_hs = 0;
            chk(req_ready == 1'b0, "R10", "req_ready while busy", req_ready, 0);
            chk(txn_valid == 1'b1, "R10", "txn_valid while busy", txn_valid, 1);
            if (held) begin
               chk(txn_base == hb && txn_bytes == hy && txn_lanes == hl, "R9",
                   "stalled transaction changed", txn_base, hb);
            end
            txn_ready = ($urandom % 4) != 0;
            if (txn_valid && txn_ready) begin
               held = 0;
               prev_hs = 1;
               if (idx < en) begin
                  chk(txn_base == eb[idx], tag, "base", txn_base, eb[idx]);
                  chk(int'(txn_bytes) == ebytes[idx], sz_tag, "bytes", txn_bytes, ebytes[idx]);
                  chk(txn_lanes == el[idx], tag, "lanes", txn_lanes, el[idx]);
               end else begin
                  chk(1'b0, tag, "extra transaction", idx, en);
               end
               chk((txn_base % txn_bytes) == 0, "R2", "base alignment", txn_base, 0);
               chk((served & txn_lanes) == '0, "R2", "lane served twice", served & txn_lanes, 0);
               for (int k = 0; k < N; k++) begin
                  if (txn_lanes[k]) begin
                     logic [AW-1:0] ak = la[k] & ~AW'(es - 1);
                     if (!(ak >= txn_base && ak < txn_base + AW'(txn_bytes)))
                        chk(1'b0, "R2", "lane outside segment", ak, txn_base);
                  end
               end
               served = served | txn_lanes;
               idx++;
            end else begin
               held = txn_valid;
               hb = txn_base; hy = txn_bytes; hl = txn_lanes;
            end
         end
         cyc++;
         @(negedge clk);
      end
      chk(got_done, "R10", "done seen", got_done, 1);
      chk(done == 1'b0, "R10", "done one cycle only", done, 0);
      txn_ready = 1'b0;
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      chk(1'b0, "R10", "watchdog expired", 0, 1);
      report();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(txn_valid == 1'b0, "R1", "txn_valid after reset", txn_valid, 0);
      chk(done == 1'b0, "R1", "done after reset", done, 0);
      chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // contiguous 4-byte lanes, one block
      lleg = 0; lesz = 0; lmask = '1;
      for (int k = 0; k < N; k++) la[k] = 32'd128 + 32'(4 * k);
      run_req("R3", "R4");
      // permuted lanes in the same block
      for (int k = 0; k < N; k++) la[k] = 32'd128 + 32'(4 * ((k * 7) % N));
      run_req("R3", "R4");
      // start off a 64-byte boundary: two segments of different sizes
      for (int k = 0; k < N; k++) la[k] = 32'd116 + 32'(4 * k);
      run_req("R3", "R4");
      // every lane on one address
      for (int k = 0; k < N; k++) la[k] = 32'h1000;
      run_req("R3", "R4");
      // stray low address bits, 8-byte elements
      lesz = 1;
      for (int k = 0; k < N; k++) la[k] = 32'h2000 + 32'(8 * k) + 32'(k % 8);
      run_req("R5", "R5");
      // empty masks in both policies
      lmask = '0; run_req("R11", "R11");
      lleg = 1;   run_req("R11", "R11");
      // strict policy, perfect regions for each element size
      for (int s = 0; s < 3; s++) begin
         int es;
         lesz = 2'(s); es = esize(lesz); lmask = '1;
         for (int k = 0; k < N; k++) la[k] = 32'h4000 + 32'(k * es);
         run_req("R6", "R6");
      end
      // strict policy with idle lanes
      lesz = 0; lmask = 16'b0110_1011_0001_1100;
      for (int k = 0; k < N; k++) la[k] = 32'h3040 + 32'(4 * k);
      run_req("R7", "R7");
      // strict policy, swapped lanes
      lmask = '1;
      for (int k = 0; k < N; k++) la[k] = 32'h3040 + 32'(4 * k);
      la[2] = 32'h3040 + 32'd12; la[3] = 32'h3040 + 32'd8;
      run_req("R8", "R8");
      // strict policy, misaligned start
      for (int k = 0; k < N; k++) la[k] = 32'h3044 + 32'(4 * k);
      run_req("R8", "R8");

      // random default-policy requests
      for (int t = 0; t < 60; t++) begin
         logic [AW-1:0] b = $urandom & 32'h00FF_FFFC;
         lleg = 0; lesz = 2'($urandom % 3);
         lmask = ($urandom % 3 == 0) ? '1 : N'($urandom);
         for (int k = 0; k < N; k++) la[k] = b + 32'($urandom % 512);
         run_req("R3", "R4");
      end
      // random strict-policy requests
      for (int t = 0; t < 40; t++) begin
         int es;
         logic [AW-1:0] rb;
         lleg = 1; lesz = 2'($urandom % 3); es = esize(lesz);
         rb = ($urandom & 32'h00FF_FFFF) & ~32'(16 * es - 1);
         lmask = ($urandom % 2 == 0) ? '1 : N'($urandom);
         for (int k = 0; k < N; k++) la[k] = rb + 32'(k * es);
         if ($urandom % 2 == 0) begin
            int p = $urandom % N;
            la[p] = la[p] + 32'(es * (1 + $urandom % 3));
            run_req("R8", "R8");
         end else begin
            run_req("R6", "R6");
         end
      end
      report();
   end
endmodule